// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one read or one write transfer at a time on a 20-bit bus where address, status and 16-bit data share the same pins. The core hands it a request made of a direction, a 20-bit address, a byte-high enable, a four-bit status nibble for the upper pins and, for writes, a data word. The controller then steps through the clock states T1, T2, T3 and T4. While the target holds `ready` low it inserts wait states between T3 and T4, so one transfer takes four clocks plus the number of wait states.

In T1 the full address goes out on the shared pins, and `ale` pulses so that external latches can hold it. From T2 onward the upper four pins carry the status nibble. In a read the lower sixteen pins are released and the incoming word is sampled when the data phase ends. In a write the data word is driven from T2 until T4 finishes. The strobes, the data-enable, the direction line and a three-bit cycle-type code are all decoded from the current state. At T4 the core receives a one-cycle `done` pulse, together with the captured read word.

Top module: `mxbus_cycle_ctrl`

## Requirements
- R1: After reset, and in every idle cycle: `req_ready`=1, `ale`=0, `rd_n`=`wr_n`=`den_n`=1, both output enables are 0, `stat`=3'b111, `dtr`=1 and `done`=0.
- R2: An idle cycle with `req_valid`=1 is followed by T1. For that one cycle `ale`=1, `ad_out` equals the 20-bit request address, `ad_oe_lo`=`ad_oe_hi`=1 and `bhe_o` equals the request's byte-high enable.
- R3: From T2 to the end of T4, `ad_out[19:16]` carries the status nibble latched with the request, `ad_oe_hi`=1 and `bhe_o` keeps its T1 value.
- R4: In a read, `ad_oe_lo`=0 from T2 to T4. `rd_n`=0 in T2, T3 and every wait state. `den_n`=0 from T2 to T4. `dtr`=0 from T1 to T4.
- R5: In a write, `ad_oe_lo`=1 and `ad_out[15:0]` equals the write word from T2 to T4. `wr_n`=0 in T2, T3 and every wait state. `dtr`=1 throughout.
- R6: `ready` is sampled only on the clock edge that ends T3 or a wait state. If it is 0, another wait state follows; if it is 1, T4 follows. A transfer with n wait states therefore lasts 4+n clocks. Both strobes return high in T4.
- R7: `stat` is 3'b101 for a read and 3'b110 for a write during T1 and T2. It is 3'b111 from T3 onward and while idle.
- R8: In a read, `ad_in` is captured on the edge where `ready`=1 ends T3 or a wait state. `rd_data` presents that word in T4 and holds it until the next read capture.
- R9: A request is taken only while idle. `req_ready` is 0 from T1 to T4, and any change on the request inputs during that time has no effect on the transfer in progress.
- R10: `done` is 1 for exactly the T4 cycle of every read or write and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core asks for a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Transfer address |
| req_bhe | input | 1 | Byte-high enable for the transfer |
| req_hstat | input | 4 | Status nibble placed on the upper pins from T2 |
| req_wdata | input | 16 | Write word |
| req_ready | output | 1 | Controller is idle and will take a request |
| done | output | 1 | Transfer finishing (T4) |
| rd_data | output | 16 | Last captured read word |
| ready | input | 1 | Target ready; low inserts wait states |
| ad_in | input | 16 | Lower shared pins as seen from the bus |
| ad_out | output | 20 | Value driven on the shared pins |
| ad_oe_lo | output | 1 | Enable for the lower 16 shared pins |
| ad_oe_hi | output | 1 | Enable for the upper 4 shared pins and `bhe_o` |
| bhe_o | output | 1 | Byte-high enable pin |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data transceiver enable, active low |
| dtr | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| stat | output | 3 | Cycle-type code |

## Verification
The assertions assume that `ready` is a clean level, sampled on each rising edge, and that `req_valid` is raised only as a level that the controller's own idle indication qualifies. The bench changes every input on the falling edge, so each edge sees settled values. Wait counts range from none to five, and `ad_in` holds the complement of the expected word until the cycle in which `ready` rises. One run keeps `req_valid` high and scrambles the request fields while a transfer is busy, and one run drops reset in the middle of a transfer.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_st_e;

  localparam logic [2:0] CODE_RD      = 3'b101;
  localparam logic [2:0] CODE_WR      = 3'b110;
  localparam logic [2:0] CODE_PASSIVE = 3'b111;

  // cycle-type code shown during T1 and T2
  function automatic logic [2:0] f_type_code(input logic wr);
    return wr ? CODE_WR : CODE_RD;
  endfunction

  // states in which a strobe is held low
  function automatic logic f_strobe_state(input bus_st_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction

  // states after address time in which the bus is owned
  function automatic logic f_data_state(input bus_st_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW) || (s == ST_T4);
  endfunction

  // states whose closing edge samples ready
  function automatic logic f_sample_state(input bus_st_e s);
    return (s == ST_T3) || (s == ST_TW);
  endfunction

  // transfer length in clocks for a given wait count
  function automatic int unsigned f_cycle_len(input int unsigned waits);
    return 4 + waits;
  endfunction

endpackage

// File: rtl/mxbus_fsm.sv
module mxbus_fsm
  import mxbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_bhe,
  input  logic [HW-1:0] req_hstat,
  input  logic [DW-1:0] req_wdata,
  input  logic          ready,
  output bus_st_e       state,
  output logic          lat_write,
  output logic [AW-1:0] lat_addr,
  output logic          lat_bhe,
  output logic [HW-1:0] lat_hstat,
  output logic [DW-1:0] lat_wdata,
  output logic          req_take,
  output logic          data_end
);

  bus_st_e state_nx;

  assign req_take = (state == ST_IDLE) && req_valid;
  assign data_end = f_sample_state(state) && ready;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (req_valid) state_nx = ST_T1;
      ST_T1:   state_nx = ST_T2;
      ST_T2:   state_nx = ST_T3;
      ST_T3:   state_nx = ready ? ST_T4 : ST_TW;
      ST_TW:   state_nx = ready ? ST_T4 : ST_TW;
      ST_T4:   state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_write <= 1'b0;
      lat_addr  <= '0;
      lat_bhe   <= 1'b0;
      lat_hstat <= '0;
      lat_wdata <= '0;
    end else if (req_take) begin
      lat_write <= req_write;
      lat_addr  <= req_addr;
      lat_bhe   <= req_bhe;
      lat_hstat <= req_hstat;
      lat_wdata <= req_wdata;
    end
  end

endmodule

// File: rtl/mxbus_drive.sv
module mxbus_drive
  import mxbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  bus_st_e       state,
  input  logic          lat_write,
  input  logic [AW-1:0] lat_addr,
  input  logic          lat_bhe,
  input  logic [HW-1:0] lat_hstat,
  input  logic [DW-1:0] lat_wdata,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe_lo,
  output logic          ad_oe_hi,
  output logic          bhe_o,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          dtr,
  output logic [2:0]    stat,
  output logic          done,
  output logic          req_ready
);

  logic in_t1, in_data, in_strobe, busy;

  assign in_t1     = (state == ST_T1);
  assign in_data   = f_data_state(state);
  assign in_strobe = f_strobe_state(state);
  assign busy      = in_t1 || in_data;

  // shared pins: address in T1, then status nibble and write word
  always_comb begin
    if (in_t1) begin
      ad_out = lat_addr;
    end else begin
      ad_out[AW-1:DW] = lat_hstat;
      ad_out[DW-1:0]  = lat_write ? lat_wdata : '0;
    end
  end

  assign ad_oe_hi  = busy;
  assign ad_oe_lo  = in_t1 || (in_data && lat_write);
  assign bhe_o     = busy ? lat_bhe : 1'b0;
  assign ale       = in_t1;
  assign rd_n      = !(in_strobe && !lat_write);
  assign wr_n      = !(in_strobe && lat_write);
  assign den_n     = !in_data;
  assign dtr       = busy ? lat_write : 1'b1;
  assign stat      = (in_t1 || state == ST_T2) ? f_type_code(lat_write) : CODE_PASSIVE;
  assign done      = (state == ST_T4);
  assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/mxbus_rdcap.sv
module mxbus_rdcap #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_end,
  input  logic          lat_write,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rd_data <= '0;
    else if (data_end && !lat_write) rd_data <= ad_in;
  end

endmodule

// File: rtl/mxbus_cycle_ctrl.sv
module mxbus_cycle_ctrl
  import mxbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_bhe,
  input  logic [HW-1:0] req_hstat,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  input  logic          ready,
  input  logic [DW-1:0] ad_in,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe_lo,
  output logic          ad_oe_hi,
  output logic          bhe_o,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          dtr,
  output logic [2:0]    stat
);

  bus_st_e       state;
  logic          lat_write;
  logic [AW-1:0] lat_addr;
  logic          lat_bhe;
  logic [HW-1:0] lat_hstat;
  logic [DW-1:0] lat_wdata;
  logic          req_take;
  logic          data_end;

  // named events for the checker
  logic st_sample;
  logic st_wait;
  assign st_sample = f_sample_state(state);
  assign st_wait   = (state == ST_TW);

  mxbus_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_bhe   (req_bhe),
    .req_hstat (req_hstat),
    .req_wdata (req_wdata),
    .ready     (ready),
    .state     (state),
    .lat_write (lat_write),
    .lat_addr  (lat_addr),
    .lat_bhe   (lat_bhe),
    .lat_hstat (lat_hstat),
    .lat_wdata (lat_wdata),
    .req_take  (req_take),
    .data_end  (data_end)
  );

  mxbus_drive #(.AW(AW), .DW(DW)) u_drive (
    .state     (state),
    .lat_write (lat_write),
    .lat_addr  (lat_addr),
    .lat_bhe   (lat_bhe),
    .lat_hstat (lat_hstat),
    .lat_wdata (lat_wdata),
    .ad_out    (ad_out),
    .ad_oe_lo  (ad_oe_lo),
    .ad_oe_hi  (ad_oe_hi),
    .bhe_o     (bhe_o),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .den_n     (den_n),
    .dtr       (dtr),
    .stat      (stat),
    .done      (done),
    .req_ready (req_ready)
  );

  mxbus_rdcap #(.DW(DW)) u_rdcap (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_end  (data_end),
    .lat_write (lat_write),
    .ad_in     (ad_in),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/mxbus_ctrl_chk.sv
module mxbus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_take,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       den_n,
  input logic       dtr,
  input logic       ad_oe_lo,
  input logic       ad_oe_hi,
  input logic [2:0] stat,
  input logic       done,
  input logic       st_sample,
  input logic       st_wait
);

  p_ale_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_ale_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> $past(req_valid && req_ready));

  p_take_to_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> (ale && ad_oe_lo && ad_oe_hi));

  p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!ad_oe_lo && !dtr && !den_n));

  p_write_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe_lo && dtr && !den_n));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_upper_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n || done) |-> ad_oe_hi);

  p_wait_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_sample && !ready) |=> (st_wait && !done));

  p_end_on_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_sample && ready) |=> (done && rd_n && wr_n));

  p_stat_passive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done || st_sample) |-> (stat == 3'b111));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

endmodule

bind mxbus_cycle_ctrl mxbus_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_take  (req_take),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .den_n     (den_n),
  .dtr       (dtr),
  .ad_oe_lo  (ad_oe_lo),
  .ad_oe_hi  (ad_oe_hi),
  .stat      (stat),
  .done      (done),
  .st_sample (st_sample),
  .st_wait   (st_wait)
);

// File: tb/mxbus_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module mxbus_cycle_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_bhe = 1'b0;
  logic [3:0]  req_hstat = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, done;
  logic [15:0] rd_data;
  logic        ready = 1'b0;
  logic [15:0] ad_in = '0;
  logic [19:0] ad_out;
  logic        ad_oe_lo, ad_oe_hi, bhe_o, ale, rd_n, wr_n, den_n, dtr;
  logic [2:0]  stat;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mxbus_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_bhe(req_bhe), .req_hstat(req_hstat),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
    .rd_data(rd_data), .ready(ready), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi), .bhe_o(bhe_o), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dtr(dtr), .stat(stat)
  );

  // vector: {wr, bhe, hstat[3:0], nwait[3:0], addr[19:0], wdata[15:0], rdval[15:0]}
  localparam int NV = 6;
  localparam logic [61:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'h3, 4'd0, 20'hFFFF0, 16'h0000, 16'hA55A},
    {1'b1, 1'b0, 4'h5, 4'd0, 20'h12345, 16'hBEEF, 16'h0000},
    {1'b0, 1'b1, 4'hA, 4'd3, 20'h0ABCD, 16'h0000, 16'h1357},
    {1'b1, 1'b1, 4'hC, 4'd2, 20'h80001, 16'h0F0F, 16'h0000},
    {1'b0, 1'b0, 4'h0, 4'd1, 20'h00000, 16'h0000, 16'hFFFF},
    {1'b1, 1'b0, 4'hF, 4'd5, 20'hFFFFF, 16'h8001, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R1 req_ready"}, 32'(req_ready), 32'd1);
    chk({tag, " R1 ale"}, 32'(ale), 32'd0);
    chk({tag, " R1 strobes/den"}, {29'd0, rd_n, wr_n, den_n}, 32'h7);
    chk({tag, " R1 oe"}, {30'd0, ad_oe_lo, ad_oe_hi}, 32'd0);
    chk({tag, " R1 stat"}, 32'(stat), 32'h7);
    chk({tag, " R1 dtr"}, 32'(dtr), 32'd1);
    chk({tag, " R10 done idle"}, 32'(done), 32'd0);
  endtask

  task automatic run_vec(input logic [61:0] v, input bit hold_req);
    logic        wr    = v[61];
    logic        bhe   = v[60];
    logic [3:0]  hs    = v[59:56];
    int          nw    = int'(v[55:52]);
    logic [19:0] addr  = v[51:32];
    logic [15:0] wd    = v[31:16];
    logic [15:0] rv    = v[15:0];
    logic [2:0]  code  = wr ? 3'b110 : 3'b101;
    int          clen  = 0;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_bhe = bhe;
    req_hstat = hs; req_wdata = wd; ready = 1'b0; ad_in = ~rv;
    tick(); clen++;
    // T1
    chk("R2 ale in T1", 32'(ale), 32'd1);
    chk("R2 address", 32'(ad_out), 32'(addr));
    chk("R2 oe in T1", {30'd0, ad_oe_lo, ad_oe_hi}, 32'd3);
    chk("R2 bhe", 32'(bhe_o), 32'(bhe));
    chk("R7 code in T1", 32'(stat), 32'(code));
    chk("R9 busy in T1", 32'(req_ready), 32'd0);
    chk("R4/R5 dtr T1", 32'(dtr), 32'(wr));
    if (hold_req) begin
      req_write = ~wr; req_addr = ~addr; req_bhe = ~bhe;
      req_hstat = ~hs; req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    tick(); clen++;
    // T2
    chk("R2 ale drops", 32'(ale), 32'd0);
    chk("R3 status nibble", 32'(ad_out[19:16]), 32'(hs));
    chk("R3 upper oe", 32'(ad_oe_hi), 32'd1);
    chk("R3 bhe held", 32'(bhe_o), 32'(bhe));
    chk("R4/R5 lower oe T2", 32'(ad_oe_lo), 32'(wr));
    if (wr) chk("R5 write word T2", 32'(ad_out[15:0]), 32'(wd));
    chk("R4 rd_n T2", 32'(rd_n), 32'(wr));
    chk("R5 wr_n T2", 32'(wr_n), 32'(!wr));
    chk("R4 den T2", 32'(den_n), 32'd0);
    chk("R7 code in T2", 32'(stat), 32'(code));
    chk("R9 busy T2", 32'(req_ready), 32'd0);
    tick(); clen++;
    // T3
    chk("R7 passive T3", 32'(stat), 32'h7);
    chk("R6 strobe T3", {30'd0, rd_n, wr_n}, {30'd0, wr, !wr});
    chk("R10 no done T3", 32'(done), 32'd0);
    if (wr) chk("R9 write word kept", 32'(ad_out[15:0]), 32'(wd));
    ready = (nw == 0);
    ad_in = (nw == 0) ? rv : ~rv;
    for (int k = 0; k < nw; k++) begin
      tick(); clen++;
      chk("R6 wait state strobe", {30'd0, rd_n, wr_n}, {30'd0, wr, !wr});
      chk("R6 no done in wait", 32'(done), 32'd0);
      chk("R7 passive wait", 32'(stat), 32'h7);
      chk("R3 nibble in wait", 32'(ad_out[19:16]), 32'(hs));
      ready = (k == nw - 1);
      ad_in = (k == nw - 1) ? rv : ~rv;
    end
    tick(); clen++;
    // T4
    chk("R10 done in T4", 32'(done), 32'd1);
    chk("R6 length", 32'(clen), 32'(4 + nw));
    chk("R6 strobes high T4", {30'd0, rd_n, wr_n}, 32'd3);
    chk("R4/R5 den T4", 32'(den_n), 32'd0);
    chk("R3 upper oe T4", 32'(ad_oe_hi), 32'd1);
    chk("R4/R5 lower oe T4", 32'(ad_oe_lo), 32'(wr));
    chk("R7 passive T4", 32'(stat), 32'h7);
    if (!wr) chk("R8 read word", 32'(rd_data), 32'(rv));
    ready = 1'b0; ad_in = 16'h0; req_valid = 1'b0;
    tick();
    chk_idle("after cycle");
    if (!wr) chk("R8 read word held", 32'(rd_data), 32'(rv));
  endtask

  initial begin
    repeat (3) tick();
    chk_idle("in reset");
    chk("R8 reset rd_data", 32'(rd_data), 32'd0);
    rst_n = 1'b1;
    tick();
    chk_idle("after reset");

    // table walk
    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

    // R9: no request while idle keeps it idle
    repeat (3) tick();
    chk_idle("R9 no request");

    // R9: request inputs scrambled while busy
    run_vec({1'b1, 1'b1, 4'h6, 4'd1, 20'h3C3C3, 16'h5AA5, 16'h0000}, 1'b1);
    run_vec({1'b0, 1'b0, 4'h9, 4'd2, 20'hC3C3C, 16'h0000, 16'h2468}, 1'b1);

    // R8: a write does not disturb the last read word
    run_vec({1'b1, 1'b0, 4'h1, 4'd0, 20'h00100, 16'h7777, 16'h0000}, 1'b0);
    chk("R8 read word kept across write", 32'(rd_data), 32'h2468);

    // R1: reset in the middle of a transfer
    req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h55555; req_wdata = 16'h1111;
    tick(); req_valid = 1'b0;
    tick(); tick();
    rst_n = 1'b0;
    #1;
    chk_idle("R1 mid-cycle reset");
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk_idle("R1 after mid reset");
    run_vec({1'b0, 1'b1, 4'h2, 4'd0, 20'hABCDE, 16'h0000, 16'h9ABC}, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule